// File: doc/BRIEF.md
# Receive Character Buffer with Per-Character Error Flags

This block holds characters that a UART's receive shifter has finished assembling until the CPU collects them. Each slot keeps the 8-bit character together with three flags describing how it arrived: a parity mismatch, a missing stop bit (framing), and a line-break condition. The oldest slot is always visible on the read side. A read strobe removes that slot on the next clock edge.

The block has two modes. In buffered mode all `DEPTH` slots are used, and a programmable trigger tells the interrupt logic when enough characters are waiting. In single-holding mode only one slot is used. When a character arrives and there is no room, it is dropped, the stored characters are kept unchanged, and a sticky overrun flag is raised. A summary output reports whether any stored character carries an error flag. Register decoding, the serial receiver and interrupt priority are outside this block.

Top module: `rx_err_fifo`

## Requirements
- R1: After synchronous reset or a `clr` strobe, the buffer is empty (`level`=0, `data_rdy`=0) and `overrun` and `err_any` are low.
- R2: Characters leave in arrival order. The head entry is presented on `rd_data`, `rd_par`, `rd_frm` and `rd_brk` whenever `data_rdy` is high. `rd_pop` removes it at the next clock edge.
- R3: In buffered mode (`fifo_en`=1), up to `DEPTH` characters are stored. A `wr_vld` that finds no room is dropped, leaves the stored contents unchanged, and sets `overrun` on the next edge.
- R4: `overrun` stays high until a `lsr_rd` strobe or `clr`. When a rejected write and `lsr_rd` occur in the same cycle, the flag is set.
- R5: The trigger code `trig_sel` selects a threshold: 0→1, 1→4, 2→8, 3→14, each clamped to the active capacity. `trig_hit` is high while `level` ≥ threshold, and `rx_irq` = `trig_hit` AND `rx_ie`.
- R6: In single-holding mode (`fifo_en`=0), the capacity is one character, and a second arrival before a pop raises `overrun`.
- R7: `err_any` is high exactly while at least one stored entry has a parity, framing or break flag set.
- R8: `data_rdy` is high exactly while `level` is nonzero. `rd_pop` on an empty buffer has no effect.
- R9: When the buffer is full, a write and a pop in the same cycle are both performed: the level is unchanged and no overrun is raised.
- R10: Any change of `fifo_en`, observed on a clock edge, empties the buffer and clears `overrun`. Writes in that cycle are discarded without raising overrun.
- R11: `level` reports the number of stored characters after every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | 1 = buffered mode, 0 = single holding slot |
| clr | input | 1 | Flush strobe |
| trig_sel | input | 2 | Trigger threshold code |
| rx_ie | input | 1 | Receive interrupt enable |
| wr_vld | input | 1 | Incoming character strobe |
| wr_data | input | 8 | Incoming character |
| wr_par | input | 1 | Parity error flag of incoming character |
| wr_frm | input | 1 | Framing error flag of incoming character |
| wr_brk | input | 1 | Break flag of incoming character |
| rd_pop | input | 1 | Remove head entry |
| lsr_rd | input | 1 | Status read strobe, clears overrun |
| rd_data | output | 8 | Head character |
| rd_par | output | 1 | Head parity error flag |
| rd_frm | output | 1 | Head framing error flag |
| rd_brk | output | 1 | Head break flag |
| data_rdy | output | 1 | Buffer not empty |
| level | output | $clog2(DEPTH)+1 | Number of stored characters |
| trig_hit | output | 1 | Level at or above threshold |
| rx_irq | output | 1 | Receive interrupt request |
| overrun | output | 1 | Sticky overrun flag |
| err_any | output | 1 | Some stored entry carries an error flag |

## Verification
A wrong pointer or level shows up on `level` and `data_rdy` at the next edge. It shows up on the head fields at the next pop, at the latest after `DEPTH` characters have cycled through. An error counter that drifts shows up on `err_any` once the errored character is popped, because the output stays high, or drops too early, while clean entries remain. Overrun handling shows on the edge after the rejected write, and the retained contents are checked as each entry drains afterwards. Trigger clamping only appears at boundary levels, so the sequence steps through every level under each code in both modes.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int CHAR_W = 8;

  typedef struct packed {
    logic              brk;
    logic              frm;
    logic              par;
    logic [CHAR_W-1:0] data;
  } rxq_entry_t;

  function automatic logic entry_has_err(rxq_entry_t e);
    return e.brk | e.frm | e.par;
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  rxq_pkg::rxq_entry_t     wdata,
  input  logic [AW-1:0]           raddr,
  output rxq_pkg::rxq_entry_t     rdata
);
  rxq_pkg::rxq_entry_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rxq_trig.sv
module rxq_trig #(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input  logic          fifo_en,
  input  logic [1:0]    trig_sel,
  input  logic [LW-1:0] level,
  output logic          hit
);
  localparam int T1 = (DEPTH < 4)  ? DEPTH : 4;
  localparam int T2 = (DEPTH < 8)  ? DEPTH : 8;
  localparam int T3 = (DEPTH < 14) ? DEPTH : 14;

  logic [LW-1:0] thr;

  always_comb begin
    if (!fifo_en) thr = LW'(1);
    else begin
      unique case (trig_sel)
        2'd0: thr = LW'(1);
        2'd1: thr = LW'(T1);
        2'd2: thr = LW'(T2);
        default: thr = LW'(T3);
      endcase
    end
  end

  assign hit = (level >= thr);
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic          clr,
  input  logic          wr_vld,
  input  logic          wr_err,
  input  logic          rd_pop,
  input  logic          lsr_rd,
  input  logic          head_err,
  output logic          we,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [LW-1:0] level,
  output logic          overrun,
  output logic          err_any
);
  logic          mode_q;
  logic          flush, pop, acc, full;
  logic [LW-1:0] cap;
  logic [LW-1:0] errc;

  assign cap   = fifo_en ? LW'(DEPTH) : LW'(1);
  assign flush = clr | (fifo_en != mode_q);
  assign full  = (level >= cap);
  assign pop   = rd_pop & (level != '0) & ~flush;
  assign acc   = wr_vld & (~full | pop) & ~flush;
  assign we    = acc;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      mode_q  <= fifo_en;
      wptr    <= '0;
      rptr    <= '0;
      level   <= '0;
      errc    <= '0;
      overrun <= 1'b0;
    end else begin
      if (acc) wptr <= wptr + AW'(1);
      if (pop) rptr <= rptr + AW'(1);
      level <= level + LW'(acc) - LW'(pop);
      errc  <= errc + LW'(acc & wr_err) - LW'(pop & head_err);
      if (wr_vld && !acc)  overrun <= 1'b1;
      else if (lsr_rd)     overrun <= 1'b0;
    end
  end

  assign err_any = (errc != '0);

  // R3
  level_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_en == mode_q) |-> (level <= cap));
  // R1
  clr_empty_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (level == '0 && !overrun && !err_any));
  // R8
  pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_pop && level == '0 && !wr_vld && !flush) |=> (level == '0));
  // R7
  err_bound_chk: assert property (@(posedge clk) disable iff (rst)
    errc <= level);
  // R4
  ovr_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(wr_vld));
endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo #(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic          clr,
  input  logic [1:0]    trig_sel,
  input  logic          rx_ie,
  input  logic          wr_vld,
  input  logic [7:0]    wr_data,
  input  logic          wr_par,
  input  logic          wr_frm,
  input  logic          wr_brk,
  input  logic          rd_pop,
  input  logic          lsr_rd,
  output logic [7:0]    rd_data,
  output logic          rd_par,
  output logic          rd_frm,
  output logic          rd_brk,
  output logic          data_rdy,
  output logic [LW-1:0] level,
  output logic          trig_hit,
  output logic          rx_irq,
  output logic          overrun,
  output logic          err_any
);
  localparam int AW = $clog2(DEPTH);

  rxq_pkg::rxq_entry_t in_e, head_e;
  logic          we;
  logic [AW-1:0] wptr, rptr;

  assign in_e = '{brk: wr_brk, frm: wr_frm, par: wr_par, data: wr_data};

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .we(we), .waddr(wptr), .wdata(in_e),
    .raddr(rptr), .rdata(head_e)
  );

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .clr(clr),
    .wr_vld(wr_vld), .wr_err(rxq_pkg::entry_has_err(in_e)),
    .rd_pop(rd_pop), .lsr_rd(lsr_rd),
    .head_err(rxq_pkg::entry_has_err(head_e)),
    .we(we), .wptr(wptr), .rptr(rptr), .level(level),
    .overrun(overrun), .err_any(err_any)
  );

  rxq_trig #(.DEPTH(DEPTH)) u_trig (
    .fifo_en(fifo_en), .trig_sel(trig_sel), .level(level), .hit(trig_hit)
  );

  assign rd_data  = head_e.data;
  assign rd_par   = head_e.par;
  assign rd_frm   = head_e.frm;
  assign rd_brk   = head_e.brk;
  assign data_rdy = (level != '0);
  assign rx_irq   = trig_hit & rx_ie;

  // R5
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> (rx_ie && data_rdy));
endmodule

// File: tb/rx_err_fifo_bench.sv
module rx_err_fifo_bench;
  localparam int DEPTH = 16;
  localparam int LW = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, fifo_en = 1'b1, clr = 1'b0, rx_ie = 1'b1;
  logic [1:0] trig_sel = 2'd0;
  logic wr_vld = 1'b0, wr_par = 1'b0, wr_frm = 1'b0, wr_brk = 1'b0;
  logic [7:0] wr_data = '0;
  logic rd_pop = 1'b0, lsr_rd = 1'b0;
  logic [7:0] rd_data;
  logic rd_par, rd_frm, rd_brk, data_rdy, trig_hit, rx_irq, overrun, err_any;
  logic [LW-1:0] level;

  rx_err_fifo #(.DEPTH(DEPTH)) u_rx_err_fifo (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .clr(clr), .trig_sel(trig_sel),
    .rx_ie(rx_ie), .wr_vld(wr_vld), .wr_data(wr_data), .wr_par(wr_par),
    .wr_frm(wr_frm), .wr_brk(wr_brk), .rd_pop(rd_pop), .lsr_rd(lsr_rd),
    .rd_data(rd_data), .rd_par(rd_par), .rd_frm(rd_frm), .rd_brk(rd_brk),
    .data_rdy(data_rdy), .level(level), .trig_hit(trig_hit), .rx_irq(rx_irq),
    .overrun(overrun), .err_any(err_any)
  );

  int q[$];
  bit m_ovr = 0;
  bit m_mode = 1;
  int n_chk = 0, n_fail = 0;

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic int thr_of();
    int cap = fifo_en ? DEPTH : 1;
    int t;
    case (trig_sel)
      2'd0: t = 1;
      2'd1: t = 4;
      2'd2: t = 8;
      default: t = 14;
    endcase
    return (t > cap) ? cap : t;
  endfunction

  task automatic model_step();
    int cap = fifo_en ? DEPTH : 1;
    bit pop, acc;
    if (rst || clr || (fifo_en != m_mode)) begin
      q.delete();
      m_ovr = 0;
      m_mode = fifo_en;
    end else begin
      pop = rd_pop && q.size() > 0;
      acc = wr_vld && (q.size() < cap || pop);
      if (pop) void'(q.pop_front());
      if (acc) q.push_back({wr_brk, wr_frm, wr_par, wr_data});
      if (wr_vld && !acc) m_ovr = 1;
      else if (lsr_rd) m_ovr = 0;
    end
  endtask

  task automatic compare();
    bit e = 0;
    foreach (q[i]) if (q[i][10:8] != 0) e = 1;
    chk("R11", "level", 32'(level), 32'(q.size()));
    chk("R8", "data_rdy", 32'(data_rdy), 32'(q.size() > 0));
    if (q.size() > 0) begin
      chk("R2", "rd_data", 32'(rd_data), 32'(q[0][7:0]));
      chk("R2", "flags", 32'({rd_brk, rd_frm, rd_par}), 32'(q[0][10:8]));
    end
    chk("R3", "overrun", 32'(overrun), 32'(m_ovr));
    chk("R7", "err_any", 32'(err_any), 32'(e));
    chk("R5", "trig_hit", 32'(trig_hit), 32'(q.size() >= thr_of()));
    chk("R5", "rx_irq", 32'(rx_irq), 32'(rx_ie && q.size() >= thr_of()));
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic cyc(bit wv, logic [10:0] ent, bit pop, bit lsr, bit c);
    wr_vld = wv; {wr_brk, wr_frm, wr_par, wr_data} = ent;
    rd_pop = pop; lsr_rd = lsr; clr = c;
    tick();
    wr_vld = 0; rd_pop = 0; lsr_rd = 0; clr = 0;
  endtask

  bit done = 0;
  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick(); tick();
    rst = 0;
    // R1 reset state
    chk("R1", "level after reset", 32'(level), 0);
    chk("R1", "overrun after reset", 32'(overrun), 0);
    chk("R1", "err_any after reset", 32'(err_any), 0);
    // R2 ordering with mixed flags
    cyc(1, 11'h0A5, 0, 0, 0);
    cyc(1, 11'h13C, 0, 0, 0);
    cyc(1, 11'h2FF, 0, 0, 0);
    cyc(1, 11'h401, 0, 0, 0);
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, 0, 0);
    // R3 fill past capacity, trigger code 3
    trig_sel = 2'd3;
    for (int i = 0; i < DEPTH + 2; i++) cyc(1, 11'(i * 7 + (i == 5 ? 11'h100 : 0)), 0, 0, 0);
    chk("R3", "level at full", 32'(level), DEPTH);
    // R9 push and pop together while full
    cyc(1, 11'h055, 1, 1, 0);
    chk("R9", "overrun cleared, no new overrun", 32'(overrun), 0);
    chk("R9", "level unchanged", 32'(level), DEPTH);
    // R4 set wins over status read
    cyc(1, 11'h066, 0, 1, 0);
    chk("R4", "overrun set wins", 32'(overrun), 1);
    cyc(0, 0, 0, 1, 0);
    chk("R4", "overrun cleared by status read", 32'(overrun), 0);
    // R5 every code over draining levels
    for (int t = 0; t < 4; t++) begin
      trig_sel = 2'(t);
      rx_ie = (t != 2);
      for (int i = 0; i < 5; i++) cyc(0, 0, 1, 0, 0);
    end
    // R1 flush strobe
    cyc(1, 11'h111, 0, 0, 0);
    cyc(0, 0, 0, 0, 1);
    chk("R1", "level after clr", 32'(level), 0);
    chk("R1", "err_any after clr", 32'(err_any), 0);
    // R10 mode change flushes
    cyc(1, 11'h012, 0, 0, 0);
    cyc(1, 11'h013, 0, 0, 0);
    fifo_en = 0;
    cyc(1, 11'h014, 0, 0, 0);
    chk("R10", "level after mode change", 32'(level), 0);
    // R6 single holding slot
    cyc(1, 11'h021, 0, 0, 0);
    cyc(1, 11'h022, 0, 0, 0);
    chk("R6", "overrun on second char", 32'(overrun), 1);
    chk("R6", "level single mode", 32'(level), 1);
    cyc(0, 0, 1, 0, 0);
    fifo_en = 1;
    cyc(0, 0, 0, 0, 0);
    chk("R10", "overrun after mode change", 32'(overrun), 0);
    // R8 pop on empty
    cyc(0, 0, 1, 0, 0);
    chk("R8", "pop on empty", 32'(level), 0);
    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      if (i % 700 == 699) fifo_en = ~fifo_en;
      trig_sel = 2'($urandom_range(0, 3));
      rx_ie = 1'($urandom_range(0, 1));
      cyc(($urandom_range(0, 9) < 6), 11'($urandom_range(0, 2047) & ($urandom_range(0, 3) == 0 ? 11'h7FF : 11'h0FF)),
          ($urandom_range(0, 9) < 5), ($urandom_range(0, 15) == 0), ($urandom_range(0, 199) == 0));
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule